// File: doc/BRIEF.md
# Flux Write Pulse Generator

This block turns a stream of 16-bit interval values into the write-data waveform of a floppy drive. A tick counter runs at the sample rate, which is the system clock divided by a programmable prescaler. It counts from zero up to the current interval value and then reloads. Each period opens with an active pulse of fixed width, and the line then stays inactive until the reload. The spacing between pulses therefore follows the stream, while the pulse width stays the same.

Interval values come from a circular buffer through a read port with one cycle of latency. The address increments and wraps. The next value is fetched while the current period is still running, so a reload never has to wait for memory. The output is active-low and is meant for an open-drain pad: logic 0 means a pulse.

Top module: `flux_pulse_gen`

## Requirements
- R1: While `en_i` is low, `wdata_no` is 1, `rd_addr_o` is 0 one clock after `en_i` is seen low, and `rd_en_o` is 0.
- R2: After `en_i` rises, buffer entries 0 and 1 are read in the first two clocks. `rd_addr_o` reads 1 and then 2, and `wdata_no` stays 1 until the second clock edge. From that edge on, the first period runs with tick count 0.
- R3: Sample ticks occur every `psc_i`+1 clocks, so each tick-count value lasts `psc_i`+1 clocks.
- R4: Each period starts with `pulse_w_i` ticks during which `wdata_no` is 0.
- R5: After the pulse, `wdata_no` is 1 until the reload. A period with interval value P lasts P+1 ticks.
- R6: Successive periods use successive buffer entries, starting at entry 0.
- R7: The read address increments by one on every buffer read and wraps from 2^ADDR_W-1 to 0.
- R8: An interval value below `pulse_w_i` is clamped to `pulse_w_i`, so each pulse is followed by at least one inactive tick.
- R9: Reloads on consecutive clocks (prescaler 0, interval 0) each take a fresh entry, and no period is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low stops the output and rewinds the buffer index |
| psc_i | input | PSC_W | Prescaler; one sample tick every psc_i+1 clocks |
| pulse_w_i | input | CNT_W | Pulse width in sample ticks |
| rd_data_i | input | CNT_W | Buffer data, valid one clock after rd_en_o |
| rd_en_o | output | 1 | Buffer read strobe |
| rd_addr_o | output | ADDR_W | Buffer read address |
| wdata_no | output | 1 | Write-data line, active low |

## Verification
On every cycle, the embedded assertions check the following:
- the line stays inactive when the block is not running;
- the tick count stays within the clamped period;
- the tick at a reload is always inactive;
- the prescaler count stays in range;
- each read moves the address forward by one;
- the priming sequence after an enable is followed.

Only the bench's reference model can show the values that depend on the stream:
- the exact placement of each pulse under different prescaler, width and interval settings;
- which entry each period uses;
- the address wrapping at the buffer end;
- correct behaviour when reloads fall on consecutive clocks.

// File: rtl/flux_pkg.sv
package flux_pkg;
  typedef enum logic [1:0] {
    ST_OFF,
    ST_PRIME,
    ST_RUN
  } fetch_st_e;
endpackage

// File: rtl/flux_prescaler.sv
module flux_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PSC_W-1:0] div_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // R3
  psc_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= div_i);
  // R3
  psc_space_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0) |=> !tick_o);
endmodule

// File: rtl/flux_fetch.sv
module flux_fetch
  import flux_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              reload_i,
  input  logic [CNT_W-1:0]  rd_data_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              run_o,
  output logic              prime_o,
  output logic [CNT_W-1:0]  next_o
);
  fetch_st_e         st_q;
  logic [ADDR_W-1:0] idx_q;
  logic              pend_q;
  logic [CNT_W-1:0]  next_q;

  assign run_o     = (st_q == ST_RUN);
  assign prime_o   = (st_q == ST_PRIME);
  assign rd_addr_o = idx_q;
  // bypass: a read still in flight is the freshest entry
  assign next_o    = pend_q ? rd_data_i : next_q;

  always_comb begin
    rd_en_o = 1'b0;
    if (en_i) begin
      unique case (st_q)
        ST_OFF:   rd_en_o = 1'b1;
        ST_PRIME: rd_en_o = 1'b1;
        ST_RUN:   rd_en_o = reload_i;
        default:  rd_en_o = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_OFF;
      idx_q  <= '0;
      pend_q <= 1'b0;
      next_q <= '0;
    end else if (!en_i) begin
      st_q   <= ST_OFF;
      idx_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_OFF:   st_q <= ST_PRIME;
        ST_PRIME: st_q <= ST_RUN;
        default:  st_q <= st_q;
      endcase
      if (rd_en_o) idx_q <= idx_q + 1'b1;
      pend_q <= rd_en_o;
      if (pend_q) next_q <= rd_data_i;
    end
  end

  // R7
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |=> rd_addr_o == ADDR_W'($past(rd_addr_o) + 1'b1));
  // R1
  off_rewind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (rd_addr_o == '0) && !run_o);
  // R2
  prime_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prime_o && en_i) |=> run_o);
endmodule

// File: rtl/flux_period_ctr.sv
module flux_period_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             prime_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] next_i,
  input  logic [CNT_W-1:0] pulse_w_i,
  output logic             reload_o,
  output logic             active_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cur_q;
  logic [CNT_W-1:0] eff;

  // clamp keeps at least one inactive tick after every pulse
  assign eff      = (cur_q < pulse_w_i) ? pulse_w_i : cur_q;
  assign reload_o = run_i && tick_i && (cnt_q >= eff);
  assign active_o = run_i && (cnt_q < pulse_w_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cur_q <= '0;
    end else if (prime_i) begin
      cnt_q <= '0;
      cur_q <= next_i;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (reload_o) begin
        cnt_q <= '0;
        cur_q <= next_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= eff);
  // R8
  gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_o |-> !active_o);
endmodule

// File: rtl/flux_pulse_gen.sv
module flux_pulse_gen #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 6,
  parameter int PSC_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [PSC_W-1:0]  psc_i,
  input  logic [CNT_W-1:0]  pulse_w_i,
  input  logic [CNT_W-1:0]  rd_data_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wdata_no
);
  logic             run;
  logic             prime;
  logic             tick;
  logic             reload;
  logic             active;
  logic [CNT_W-1:0] next_val;

  flux_prescaler #(.PSC_W(PSC_W)) i_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .div_i  (psc_i),
    .tick_o (tick)
  );

  flux_fetch #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_fetch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .reload_i  (reload),
    .rd_data_i (rd_data_i),
    .rd_en_o   (rd_en_o),
    .rd_addr_o (rd_addr_o),
    .run_o     (run),
    .prime_o   (prime),
    .next_o    (next_val)
  );

  flux_period_ctr #(.CNT_W(CNT_W)) i_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .prime_i   (prime),
    .tick_i    (tick),
    .next_i    (next_val),
    .pulse_w_i (pulse_w_i),
    .reload_o  (reload),
    .active_o  (active)
  );

  assign wdata_no = !active;

  // R1
  idle_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> wdata_no);
  // R1
  idle_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !rd_en_o);
endmodule

// File: tb/test_flux_pulse_gen.sv
module test_flux_pulse_gen;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 6;
  localparam int PSC_W  = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              en = 1'b0;
  logic [PSC_W-1:0]  psc = '0;
  logic [CNT_W-1:0]  pw = '0;
  logic [CNT_W-1:0]  rd_data = '0;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic              wdata_n;
  logic [CNT_W-1:0]  mem [DEPTH];

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  string tag = "R1";

  // reference model state
  int m_st, m_rd, m_cnt, m_psc, m_per, m_k, m_eff;
  int prev_addr = 0;
  bit saw_wrap = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flux_pulse_gen #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .PSC_W(PSC_W)) i_flux_pulse_gen (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .en_i      (en),
    .psc_i     (psc),
    .pulse_w_i (pw),
    .rd_data_i (rd_data),
    .rd_en_o   (rd_en),
    .rd_addr_o (rd_addr),
    .wdata_no  (wdata_n)
  );

  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d t=%0t", req, got, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_rd = 0; m_cnt = 0; m_psc = 0; m_per = 0; m_k = 0;
    end else if (!en) begin
      m_st = 0; m_rd = 0; m_cnt = 0; m_psc = 0; m_k = 0;
    end else if (m_st == 0) begin
      m_st = 1; m_rd = 1;
    end else if (m_st == 1) begin
      m_st = 2; m_per = mem[0]; m_k = 1; m_rd = 2; m_cnt = 0; m_psc = 0;
    end else begin
      if (m_psc == int'(psc)) begin
        m_psc = 0;
        m_eff = (m_per < int'(pw)) ? int'(pw) : m_per;
        if (m_cnt >= m_eff) begin
          m_cnt = 0;
          m_per = mem[m_k % DEPTH];
          m_k++;
          m_rd++;
        end else m_cnt++;
      end else m_psc++;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(tag, wdata_n, (m_st == 2 && m_cnt < int'(pw)) ? 0 : 1);
      check(tag, rd_addr, m_rd % DEPTH);
      if (en && prev_addr == DEPTH-1 && rd_addr == 0) saw_wrap = 1;
      prev_addr = rd_addr;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stop();
    @(negedge clk) en = 1'b0;
    run(2);
  endtask

  initial begin
    int lo;
    for (int i = 0; i < DEPTH; i++) mem[i] = CNT_W'(5 + i % 4);
    run(3);
    // R1: reset state
    check("R1", wdata_n, 1);
    check("R1", rd_addr, 0);
    check("R1", rd_en, 0);
    rst_n = 1'b1;
    run(2);

    // R2 priming, R4 pulse width, R6 stream order
    tag = "R6"; psc = 0; pw = 3;
    en = 1'b1;
    @(negedge clk);
    check("R2", rd_addr, 1);
    check("R2", wdata_n, 1);
    @(negedge clk);
    check("R2", rd_addr, 2);
    check("R4", wdata_n, 0);
    lo = 1;
    while (wdata_n == 0) begin @(negedge clk); lo++; end
    check("R4", lo - 1, 3);
    run(200);

    // R1: disable mid-run
    @(negedge clk) en = 1'b0;
    @(negedge clk);
    check("R1", wdata_n, 1);
    check("R1", rd_addr, 0);
    check("R1", rd_en, 0);
    run(3);

    // R3 prescaled timing
    tag = "R3"; psc = 2; pw = 2;
    @(negedge clk) en = 1'b1;
    run(2);
    lo = 0;
    while (wdata_n == 0) begin @(negedge clk); lo++; end
    check("R3", lo, 6);
    run(300);
    stop();

    // R8 clamp
    tag = "R8"; psc = 0; pw = 3;
    for (int i = 0; i < DEPTH; i++) mem[i] = CNT_W'(i % 2);
    @(negedge clk) en = 1'b1;
    run(2 + 3);
    check("R8", wdata_n, 1);
    @(negedge clk);
    check("R8", wdata_n, 0);
    run(200);
    stop();

    // R7 wrap, R5 gap
    tag = "R7"; psc = 0; pw = 1; saw_wrap = 0;
    for (int i = 0; i < DEPTH; i++) mem[i] = 1;
    @(negedge clk) en = 1'b1;
    run(300);
    check("R7", saw_wrap, 1);
    stop();

    // R9 consecutive reloads
    tag = "R9"; psc = 0; pw = 0; saw_wrap = 0;
    for (int i = 0; i < DEPTH; i++) mem[i] = 0;
    @(negedge clk) en = 1'b1;
    run(2);
    check("R9", rd_addr, 2);
    run(1);
    check("R9", rd_addr, 3);
    run(1);
    check("R9", rd_addr, 4);
    run(150);
    check("R9", saw_wrap, 1);
    stop();

    // R5 long interval, width 1
    tag = "R5"; psc = 1; pw = 1;
    for (int i = 0; i < DEPTH; i++) mem[i] = CNT_W'(20 + i);
    @(negedge clk) en = 1'b1;
    run(600);
    stop();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule